// File: doc/BRIEF.md
# Timer Input Capture Unit

This block records the moment an external event occurs. It watches a single capture pin. When the pin shows the chosen transition, the block stores the value of a free-running 16-bit timer, which it receives on an input port, and raises a capture flag that software or an interrupt line can observe. The pin passes through a synchronizer chain before the edge is detected, so an asynchronous pin is safe to use. The synchronizer depth is a parameter.

Software reaches the block over an 8-bit register bus. Reads are combinational. Writes take effect on the clock edge. The stored capture value is wider than the bus, so it is read in two bytes through one shared holding byte. Reading the low half returns it directly and, on the same edge, copies the upper half into the holding byte. Reading the upper half returns the holding byte. The running timer is read through the same holding byte, so either low-half read replaces whatever the holding byte held.

Register addresses:

- 0: capture value, low byte.
- 1: capture value, high byte.
- 2: timer, low byte.
- 3: timer, high byte.
- 4: control. Bit 0 is the edge select.
- 5: flag. Bit 0 is the capture flag.

Top module: `icu_top`

## Requirements
- R1: After reset, every readable location returns 0: capture value, holding byte, edge select and flag. A read with bus_rd low, or of an unmapped address (6 or 7), also returns 0.
- R2: When control bit 0 is 1, a low-to-high transition of the synchronized pin triggers a capture. A high-to-low transition does not.
- R3: When control bit 0 is 0, a high-to-low transition of the synchronized pin triggers a capture. A low-to-high transition does not.
- R4: A capture loads the value count_in holds at the capture edge. The flag becomes 1 on that same edge. The capture edge is the (SYNC_STAGES+1)-th rising clock edge that samples the new pin level.
- R5: Bus writes to addresses 0 and 1 leave the capture value unchanged. Only a capture changes it.
- R6: A read of address 0 returns capture bits 7:0 and, on that edge, loads the holding byte with capture bits 15:8.
- R7: A read of address 1 or address 3 returns the holding byte, not the live upper bits.
- R8: A read of address 2 returns count_in bits 7:0 and, on that edge, loads the holding byte with count_in bits 15:8. This overwrites any byte a capture low-byte read left there.
- R9: Writing 1 to bit 0 of address 5 clears the flag. Writing 0 there has no effect.
- R10: A capture on the same edge as a flag clear leaves the flag set.
- R11: A capture that falls between the two halves of a two-byte read updates the capture value. The holding byte keeps the upper byte taken by the earlier low-byte read.
- R12: Control bit 0 is writable at address 4 and reads back there. The flag reads back at bit 0 of address 5. The other bits of both locations read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_pin | input | 1 | Asynchronous capture event pin |
| count_in | input | 2*BUS_W | Running timer value |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, valid in the cycle of the read strobe |
| cap_flag | output | 1 | Capture flag |

## Verification
The bench builds the block with SYNC_STAGES set to 3 instead of the default 2. This lengthens the latency from pin to capture, so an error of one stage in the synchronizer would show up against a model that takes the depth from the same parameter. The 8-bit bus width keeps distinct values in the two halves of the timer. Together these bring within reach the ordering cases: a clear on the same edge as a capture, and a capture between the two byte reads.

// File: rtl/icu_pkg.sv
package icu_pkg;
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_CAP_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_CAP_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd2;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd3;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd4;
    localparam logic [ADDR_W-1:0] A_FLAG   = 3'd5;
endpackage

// File: rtl/icu_sync_edge.sv
module icu_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic rise_sel_i,
    output logic fire_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
        logic                   prev;
    } sync_st_t;

    sync_st_t st_d, st_q;
    logic     level;

    assign level = st_q.chain[SYNC_STAGES-1];

    always_comb begin
        st_d          = st_q;
        st_d.chain[0] = pin_i;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
        st_d.prev = level;
        if (rise_sel_i) fire_o = level & ~st_q.prev;
        else            fire_o = ~level & st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/icu_capture.sv
module icu_capture #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cap_o,
    output logic             flag_o
);
    typedef struct packed {
        logic [CNT_W-1:0] value;
        logic             flag;
    } cap_st_t;

    cap_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fire_i) begin
            st_d.value = count_i;
            st_d.flag  = 1'b1;
        end else if (clr_i) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap_o  = st_q.value;
    assign flag_o = st_q.flag;
endmodule

// File: rtl/icu_bus.sv
module icu_bus
    import icu_pkg::*;
#(
    parameter int BUS_W = 8,
    localparam int CNT_W = 2 * BUS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BUS_W-1:0]  wdata_i,
    input  logic [CNT_W-1:0]  cap_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              flag_i,
    output logic [BUS_W-1:0]  rdata_o,
    output logic              rise_sel_o,
    output logic              clr_o,
    output logic [BUS_W-1:0]  temp_o
);
    typedef struct packed {
        logic             rise_sel;
        logic [BUS_W-1:0] temp;
    } bus_st_t;

    bus_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_i && addr_i == A_CAP_LO)      st_d.temp = cap_i[CNT_W-1:BUS_W];
        else if (rd_i && addr_i == A_CNT_LO) st_d.temp = count_i[CNT_W-1:BUS_W];
        if (wr_i && addr_i == A_CTRL)        st_d.rise_sel = wdata_i[0];
    end

    always_comb begin
        clr_o   = wr_i && (addr_i == A_FLAG) && wdata_i[0];
        rdata_o = '0;
        if (rd_i) begin
            case (addr_i)
                A_CAP_LO: rdata_o = cap_i[BUS_W-1:0];
                A_CAP_HI: rdata_o = st_q.temp;
                A_CNT_LO: rdata_o = count_i[BUS_W-1:0];
                A_CNT_HI: rdata_o = st_q.temp;
                A_CTRL:   rdata_o = {{(BUS_W-1){1'b0}}, st_q.rise_sel};
                A_FLAG:   rdata_o = {{(BUS_W-1){1'b0}}, flag_i};
                default:  rdata_o = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_sel_o = st_q.rise_sel;
    assign temp_o     = st_q.temp;
endmodule

// File: rtl/icu_top.sv
module icu_top
    import icu_pkg::*;
#(
    parameter int BUS_W       = 8,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W = 2 * BUS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_pin,
    input  logic [CNT_W-1:0]  count_in,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              cap_flag
);
    logic             rise_sel;
    logic             cap_fire;
    logic             flag_clr;
    logic [CNT_W-1:0] cap_val;
    logic [BUS_W-1:0] temp_val;

    icu_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (cap_pin),
        .rise_sel_i (rise_sel),
        .fire_o     (cap_fire)
    );

    icu_capture #(.CNT_W(CNT_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (cap_fire),
        .count_i (count_in),
        .clr_i   (flag_clr),
        .cap_o   (cap_val),
        .flag_o  (cap_flag)
    );

    icu_bus #(.BUS_W(BUS_W)) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_i       (bus_rd),
        .wr_i       (bus_wr),
        .addr_i     (bus_addr),
        .wdata_i    (bus_wdata),
        .cap_i      (cap_val),
        .count_i    (count_in),
        .flag_i     (cap_flag),
        .rdata_o    (bus_rdata),
        .rise_sel_o (rise_sel),
        .clr_o      (flag_clr),
        .temp_o     (temp_val)
    );
endmodule

// File: rtl/icu_chk.sv
module icu_chk
    import icu_pkg::*;
#(
    parameter int BUS_W = 8,
    localparam int CNT_W = 2 * BUS_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic [BUS_W-1:0]  wdata,
    input logic [BUS_W-1:0]  rdata,
    input logic [CNT_W-1:0]  count_in,
    input logic              fire,
    input logic [CNT_W-1:0]  cap_val,
    input logic [BUS_W-1:0]  temp,
    input logic              flag
);
    logic clr;
    assign clr = wr && addr == A_FLAG && wdata[0];

    // R4
    cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> cap_val == $past(count_in));

    // R10
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> flag);

    // R5
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(cap_val));

    // R6
    temp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == A_CAP_LO) |=> temp == $past(cap_val[CNT_W-1:BUS_W]));

    // R7
    high_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == A_CAP_HI) |-> rdata == temp);

    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !fire) |=> !flag);

    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !fire) |=> $stable(flag));
endmodule

bind icu_top icu_chk #(.BUS_W(BUS_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd       (bus_rd),
    .wr       (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .rdata    (bus_rdata),
    .count_in (count_in),
    .fire     (cap_fire),
    .cap_val  (cap_val),
    .temp     (temp_val),
    .flag     (cap_flag)
);

// File: tb/sim_icu_top.sv
module sim_icu_top;
    localparam int CLK_PERIOD = 10;
    localparam int SYNC = 3;
    localparam int WATCHDOG = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_pin = 1'b0;
    logic [15:0] count_in = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        cap_flag;

    int    vectors = 0;
    int    fails = 0;
    int    cycles = 0;
    string cur = "R1";

    // reference state
    logic [15:0] m_cap = '0;
    logic [7:0]  m_temp = '0;
    logic        m_ctrl = 1'b0;
    logic        m_flag = 1'b0;
    logic        hist[$];
    logic [15:0] cnt = 16'h1234;

    icu_top #(.BUS_W(8), .SYNC_STAGES(SYNC)) u0 (
        .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .count_in(count_in),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_flag(cap_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic step(input logic pin, input logic rd, input logic wr,
                        input logic [2:0] a, input logic [7:0] wd);
        logic [7:0]  exp_rd;
        logic [15:0] c;
        logic        fire;
        logic [15:0] old_cap;
        @(negedge clk);
        c = cnt;
        cnt = cnt + 16'h0135;
        cap_pin = pin; bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        count_in = c;
        #1;
        exp_rd = 8'h00;
        if (rd) begin
            case (a)
                3'd0: exp_rd = m_cap[7:0];
                3'd1: exp_rd = m_temp;
                3'd2: exp_rd = c[7:0];
                3'd3: exp_rd = m_temp;
                3'd4: exp_rd = {7'b0, m_ctrl};
                3'd5: exp_rd = {7'b0, m_flag};
                default: exp_rd = 8'h00;
            endcase
        end
        vectors++;
        if (bus_rdata !== exp_rd || cap_flag !== m_flag) begin
            fails++;
            $display("FAIL %s: rdata=%h flag=%b expected rdata=%h flag=%b",
                     cur, bus_rdata, cap_flag, exp_rd, m_flag);
        end
        @(posedge clk);
        fire = m_ctrl ? (hist[1] && !hist[0]) : (!hist[1] && hist[0]);
        old_cap = m_cap;
        if (fire) begin
            m_cap  = c;
            m_flag = 1'b1;
        end else if (wr && a == 3'd5 && wd[0]) begin
            m_flag = 1'b0;
        end
        if (rd && a == 3'd0)      m_temp = old_cap[15:8];
        else if (rd && a == 3'd2) m_temp = c[15:8];
        if (wr && a == 3'd4) m_ctrl = wd[0];
        hist.push_back(pin);
        void'(hist.pop_front());
    endtask

    task automatic idle(input logic pin, input int n);
        for (int i = 0; i < n; i++) step(pin, 1'b0, 1'b0, 3'd0, 8'h00);
    endtask

    task automatic rd(input logic pin, input logic [2:0] a);
        step(pin, 1'b1, 1'b0, a, 8'h00);
    endtask

    task automatic wr(input logic pin, input logic [2:0] a, input logic [7:0] d);
        step(pin, 1'b0, 1'b1, a, d);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                fails++;
                $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
                finish_run();
            end
        end
    end

    initial begin
        for (int i = 0; i < SYNC + 1; i++) hist.push_back(1'b0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        cur = "R1";
        for (int a = 0; a < 8; a++) rd(1'b0, 3'(a));
        step(1'b0, 1'b0, 1'b0, 3'd4, 8'h00);

        cur = "R12";
        wr(1'b0, 3'd4, 8'hFF); rd(1'b0, 3'd4);
        wr(1'b0, 3'd4, 8'h00); rd(1'b0, 3'd4);
        rd(1'b0, 3'd5);

        cur = "R3";
        idle(1'b1, 8);
        idle(1'b0, 8);
        cur = "R4";
        rd(1'b0, 3'd0);
        cur = "R7";
        rd(1'b0, 3'd1);
        cur = "R6";
        rd(1'b0, 3'd0); rd(1'b0, 3'd3);

        cur = "R5";
        wr(1'b0, 3'd0, 8'hFF); wr(1'b0, 3'd1, 8'hFF);
        rd(1'b0, 3'd0); rd(1'b0, 3'd1);

        cur = "R9";
        wr(1'b0, 3'd5, 8'hFE); rd(1'b0, 3'd5);
        wr(1'b0, 3'd5, 8'h01); rd(1'b0, 3'd5);

        cur = "R2";
        wr(1'b0, 3'd4, 8'h01);
        idle(1'b1, 8);
        rd(1'b1, 3'd0); rd(1'b1, 3'd1);
        wr(1'b1, 3'd5, 8'h01);
        idle(1'b0, 8);
        rd(1'b0, 3'd5);

        cur = "R10";
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < 6; i++) wr(1'b1, 3'd5, 8'h01);
            for (int i = 0; i < 6; i++) wr(1'b0, 3'd5, 8'h01);
        end
        rd(1'b0, 3'd5);

        cur = "R11";
        rd(1'b0, 3'd0);
        idle(1'b1, 8);
        rd(1'b1, 3'd1);
        rd(1'b1, 3'd0); rd(1'b1, 3'd1);

        cur = "R8";
        rd(1'b1, 3'd0); rd(1'b1, 3'd2); rd(1'b1, 3'd1);
        rd(1'b1, 3'd2); rd(1'b1, 3'd3);

        cur = "R6";
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[3:0] == 4'd0)
                step(r[8], 1'b0, 1'b1, r[6:4], r[15:8]);
            else
                step(r[8], r[9], 1'b0, r[6:4], 8'h00);
        end
        finish_run();
    end
endmodule